// File: doc/BRIEF.md
# Configuration Bus Width Detector

This block sits on the raw configuration input port and runs before any word assembly or packet handling. Its task is to find out how many lanes of the port the external source actually drives. It watches the lowest byte lane of every valid transfer for a fixed marker byte. The transfer that comes right after the marker holds the first byte lane of a known pattern. Because the pattern bytes differ, that first lane shows a different byte on an 8-bit, a 16-bit or a 32-bit bus, and the block uses it to tell the widths apart.

All-ones filler words and other unrelated traffic may arrive before the marker. None of them can cause a detection. Once a width is found, the block latches a two-bit code and raises a done flag. Downstream logic uses the code to choose how to pack incoming transfers into 32-bit words. The result stays fixed until the next reset.

Top module: `cfg_width_detect`

## Requirements
- R1: While reset is asserted, and on the first clock after it, `width_code` is 2'b00 and `width_done` is 0.
- R2: A valid transfer whose bits [7:0] equal 0xBB arms the detector. If the next valid transfer has bits [7:0] equal to 0x11, then `width_code` becomes 2'b01 (8-bit bus) and `width_done` becomes 1 on the clock edge that samples that transfer. Before that edge both outputs stay at their undetected values.
- R3: If the transfer after the marker has bits [7:0] equal to 0x22, the result is 2'b10 (16-bit bus), with the same timing as R2.
- R4: If the transfer after the marker has bits [7:0] equal to 0x44, the result is 2'b11 (32-bit bus), with the same timing as R2.
- R5: Cycles with `in_valid` low change nothing. They do not arm the detector, disarm it or complete a detection, whatever the data lanes hold.
- R6: All-ones filler words (0xFFFFFFFF) before the marker are ignored and leave the block searching.
- R7: Bits [31:8] of `in_data` are ignored while searching and while armed. Only bits [7:0] decide the marker and the width code.
- R8: If the valid transfer after the marker carries any other byte in bits [7:0], including 0xBB or the unused 0x33, the block goes back to searching without latching a width. That transfer does not arm the detector again.
- R9: Once `width_done` is 1, `width_code` and `width_done` hold their values until reset. Later marker or pattern transfers are ignored.
- R10: `width_done` is 1 exactly when `width_code` is not 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Qualifies `in_data` for one transfer |
| in_data | input | 32 | Raw configuration port; bits [7:0] are the lowest lane |
| width_code | output | 2 | 00 undetected, 01 8-bit, 10 16-bit, 11 32-bit |
| width_done | output | 1 | High once a width has been latched |

## Verification
The bench feeds each bus width the byte sequence that width would really deliver. On the 8-bit bus, pattern bytes arrive after the detection. A design that did not freeze its result would then switch codes on the 0x22 or 0x44 bytes that follow. Two failure cases target R8. In the first, a mismatch is followed straight away by a valid pattern byte; a design that stayed armed would latch a width there. In the second, a repeated marker byte is followed by a pattern byte, and a design that re-armed on the mismatching transfer would latch a width. Other checks put garbage in the upper lanes, and place idle cycles between marker and pattern while the data lanes hold pattern bytes. These catch a design that compared whole words or did not qualify its inputs with `in_valid`.

// File: rtl/cfg_width_detect.sv
module cfg_width_detect #(
  parameter int DATA_W = 32,
  parameter int LANE_W = 8,
  parameter logic [LANE_W-1:0] MARK_BYTE = 8'hBB,
  parameter logic [LANE_W-1:0] PAT_B8    = 8'h11,
  parameter logic [LANE_W-1:0] PAT_B16   = 8'h22,
  parameter logic [LANE_W-1:0] PAT_B32   = 8'h44
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic [1:0]        width_code,
  output logic              width_done
);

  localparam logic [1:0] CODE_NONE = 2'b00;
  localparam logic [1:0] CODE_8    = 2'b01;
  localparam logic [1:0] CODE_16   = 2'b10;
  localparam logic [1:0] CODE_32   = 2'b11;

  logic [LANE_W-1:0] low_lane;
  logic [1:0]        lane_code;
  logic              armed_q;
  logic [1:0]        code_q;
  logic              done_q;

  assign low_lane = in_data[LANE_W-1:0];

  always_comb begin
    case (low_lane)
      PAT_B8:  lane_code = CODE_8;
      PAT_B16: lane_code = CODE_16;
      PAT_B32: lane_code = CODE_32;
      default: lane_code = CODE_NONE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      code_q  <= CODE_NONE;
      done_q  <= 1'b0;
    end else if (in_valid && !done_q) begin
      if (armed_q) begin
        armed_q <= 1'b0;
        if (lane_code != CODE_NONE) begin
          code_q <= lane_code;
          done_q <= 1'b1;
        end
      end else begin
        armed_q <= (low_lane == MARK_BYTE);
      end
    end
  end

  assign width_code = code_q;
  assign width_done = done_q;

endmodule

// File: rtl/cfg_width_detect_chk.sv
module cfg_width_detect_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [31:0] in_data,
  input logic        armed,
  input logic [1:0]  width_code,
  input logic        width_done
);

  // R1
  reset_state_chk: assert property (@(posedge clk)
    !rst_n |=> (width_code == 2'b00 && !width_done));

  // R2
  lock8_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && in_valid && !width_done && in_data[7:0] == 8'h11) |=> (width_code == 2'b01 && width_done));

  // R3
  lock16_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && in_valid && !width_done && in_data[7:0] == 8'h22) |=> (width_code == 2'b10 && width_done));

  // R4
  lock32_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && in_valid && !width_done && in_data[7:0] == 8'h44) |=> (width_code == 2'b11 && width_done));

  // R5
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(armed) && $stable(width_done) && $stable(width_code)));

  // R8
  mismatch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && in_valid && !width_done && in_data[7:0] != 8'h11 && in_data[7:0] != 8'h22 && in_data[7:0] != 8'h44)
      |=> (!armed && !width_done));

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    width_done |=> (width_done && $stable(width_code)));

  // R10
  done_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    width_done == (width_code != 2'b00));

endmodule

bind cfg_width_detect cfg_width_detect_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_data    (in_data),
  .armed      (armed_q),
  .width_code (width_code),
  .width_done (width_done)
);

// File: tb/cfg_width_detect_tb.sv
module cfg_width_detect_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_data = 32'h0;
  logic [1:0]  width_code;
  logic        width_done;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  cfg_width_detect u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_data    (in_data),
    .width_code (width_code),
    .width_done (width_done)
  );

  task automatic check(input logic [1:0] exp_code, input logic exp_done, input string req);
    n_checks++;
    if (width_code !== exp_code || width_done !== exp_done) begin
      n_fails++;
      $display("FAIL %s: code=%b done=%b expected code=%b done=%b",
               req, width_code, width_done, exp_code, exp_done);
    end
  endtask

  task automatic send(input logic [31:0] w);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = w;
    @(negedge clk);
    in_valid = 1'b0;
    in_data  = 32'h0;
  endtask

  task automatic idle(input logic [31:0] w, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_data  = w;
    end
    @(negedge clk);
    in_data = 32'h0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = 1'b0;
    @(negedge clk);
    check(2'b00, 1'b0, "R1 during reset");
    rst_n = 1'b1;
    @(negedge clk);
    check(2'b00, 1'b0, "R1 after reset");
  endtask

  task automatic t_bus8();
    do_reset();
    send(32'hFFFF_FFFF);
    send(32'hFFFF_FFFF);
    check(2'b00, 1'b0, "R6 filler ignored");
    send(32'h0000_0000);
    send(32'h0000_0000);
    send(32'h0000_0000);
    send(32'h0000_00BB);
    check(2'b00, 1'b0, "R2 armed but not done");
    send(32'h0000_0011);
    check(2'b01, 1'b1, "R2 8-bit detected");
    send(32'h0000_0022);
    send(32'h0000_0000);
    send(32'h0000_0044);
    check(2'b01, 1'b1, "R9 8-bit held through later bytes");
  endtask

  task automatic t_bus16();
    do_reset();
    send(32'hFFFF_FFFF);
    send(32'h0000_0000);
    send(32'h0000_00BB);
    send(32'h0000_1122);
    check(2'b10, 1'b1, "R3 16-bit detected");
    send(32'h0000_0044);
    check(2'b10, 1'b1, "R9 16-bit held");
  endtask

  task automatic t_bus32();
    do_reset();
    send(32'hFFFF_FFFF);
    send(32'h0000_00BB);
    send(32'h1122_0044);
    check(2'b11, 1'b1, "R4 32-bit detected");
    send(32'h0000_00BB);
    send(32'h0000_0011);
    check(2'b11, 1'b1, "R9 later marker ignored");
  endtask

  task automatic t_gaps();
    do_reset();
    idle(32'h0000_00BB, 3);
    send(32'h0000_0011);
    check(2'b00, 1'b0, "R5 invalid marker does not arm");
    send(32'h0000_00BB);
    idle(32'h0000_0044, 4);
    check(2'b00, 1'b0, "R5 invalid pattern ignored");
    send(32'h0000_0022);
    check(2'b10, 1'b1, "R5 armed state kept across idle");
  endtask

  task automatic t_upper();
    do_reset();
    send(32'hDEAD_12BB);
    send(32'hABCD_EF44);
    check(2'b11, 1'b1, "R7 upper lanes ignored");
    check(2'b11, 1'b1, "R10 done matches code");
  endtask

  task automatic t_mismatch();
    do_reset();
    send(32'h0000_00BB);
    send(32'h0000_0033);
    check(2'b00, 1'b0, "R8 0x33 rejected");
    send(32'h0000_0044);
    check(2'b00, 1'b0, "R8 back to searching");
    send(32'h0000_00BB);
    send(32'h0000_00BB);
    send(32'h0000_0044);
    check(2'b00, 1'b0, "R8 repeated marker does not re-arm");
    send(32'h0000_00BB);
    send(32'h0000_0022);
    check(2'b10, 1'b1, "R8 later good sequence detected");
    do_reset();
  endtask

  initial begin
    repeat (2) @(negedge clk);
    t_bus8();
    t_bus16();
    t_bus32();
    t_gaps();
    t_upper();
    t_mismatch();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

endmodule